// File: doc/BRIEF.md
# Receive Character Parity and Overrun Stage

This stage sits behind a serial deserialiser on one terminal line. Each time the deserialiser presents a finished character with a one-cycle valid strobe, the stage rewrites the top bit according to the selected parity mode, latches the result into its receive buffer, and updates three status flags: character ready, overrun and odd-parity. When interrupts are enabled, it also raises a one-cycle request.

The parity mode can force the top bit so that the character has odd weight, force it so that it has even weight, or leave the received bit in place. After every store, a status flag reports whether the stored character has an odd number of ones. When a character arrives while the previous one is still marked ready, the stage flags an overrun and still overwrites the buffer. A status-clear strobe, issued when software consumes the status, clears the ready and overrun flags. A character that arrives together with a break indication is dropped.

Top module: `rxp_char_stage`

## Requirements
- R1: After reset, the buffer reads 0x00 and the ready, overrun, odd-parity and interrupt outputs are all 0.
- R2: With mode code 2'b01 (odd), the stored bit 7 is the inverse of the XOR of received bits 6..0, so the stored byte has an odd number of ones. Bits 6..0 are stored unchanged.
- R3: With mode code 2'b10 (even), the stored bit 7 is the XOR of received bits 6..0, which is the complement of the odd-mode bit. Bits 6..0 are stored unchanged.
- R4: With mode code 2'b00 or 2'b11 (no parity), all 8 received bits are stored unchanged.
- R5: After each store, the odd-parity flag is 1 exactly when the stored byte has an odd number of ones.
- R6: An accepted character appears on the buffer output and sets the ready flag in the cycle after its strobe.
- R7: If the ready flag is already 1 when a character is accepted, the overrun flag becomes 1 and the buffer still takes the new character.
- R8: When interrupt enable is 1 at acceptance, the interrupt output is 1 for exactly the one cycle after the strobe. When interrupt enable is 0, the interrupt output stays 0.
- R9: A strobe together with the break input leaves the buffer and all flags unchanged and raises no interrupt.
- R10: A status-clear strobe clears the ready and overrun flags in the next cycle. If a character is accepted in the same cycle as the clear, the clear acts first: ready ends at 1 and overrun at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_break | input | 1 | Break condition on the line; drops the strobed character |
| rx_data | input | 8 | Received character |
| par_mode | input | 2 | 00/11 none, 01 odd, 10 even |
| irq_en | input | 1 | Interrupt enable |
| stat_clr | input | 1 | Status consumed: clear ready and overrun |
| rx_buf | output | 8 | Stored character |
| rx_done | output | 1 | Character ready |
| rx_overrun | output | 1 | Character lost to overwrite |
| rx_par_odd | output | 1 | Stored character has odd weight |
| rx_irq | output | 1 | One-cycle interrupt request |

## Verification
The hardest case to reach is a status clear that lands in the same cycle as a new character, because the clear and the overrun detection compete for the overrun flag. The bench first leaves the ready flag set from an earlier character. It then drives the clear strobe and a new character on the same edge and expects ready set with overrun clear. A break-qualified strobe is sent while ready and overrun are both set, so that any unwanted update would show on the outputs.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_RAW  = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic done;
        logic ovr;
        logic par_odd;
        logic irq;
    } rx_flags_t;

endpackage

// File: rtl/rxp_parity_gen.sv
module rxp_parity_gen #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] raw_char,
    input  logic [1:0]        mode,
    output logic [DATA_W-1:0] stored_char,
    output logic              weight_odd
);
    import rxp_pkg::*;

    localparam int TOP = DATA_W - 1;

    logic fill_bit;

    // bit that gives the full character odd weight
    assign fill_bit = ~(^raw_char[TOP-1:0]);

    always_comb begin
        stored_char = raw_char;
        case (par_mode_e'(mode))
            PAR_ODD:  stored_char[TOP] = fill_bit;
            PAR_EVEN: stored_char[TOP] = ~fill_bit;
            default:  stored_char[TOP] = raw_char[TOP];
        endcase
        weight_odd = (stored_char[TOP] == fill_bit);
    end

endmodule

// File: rtl/rxp_flag_next.sv
module rxp_flag_next (
    input  logic               accept,
    input  logic               clr,
    input  logic               int_en,
    input  logic               new_par_odd,
    input  rxp_pkg::rx_flags_t cur,
    output rxp_pkg::rx_flags_t nxt
);
    always_comb begin
        nxt     = cur;
        nxt.irq = 1'b0;
        if (clr) begin
            nxt.done = 1'b0;
            nxt.ovr  = 1'b0;
        end
        if (accept) begin
            // a pending clear is applied before the arrival is judged
            if (cur.done && !clr) begin
                nxt.ovr = 1'b1;
            end
            nxt.done    = 1'b1;
            nxt.par_odd = new_par_odd;
            nxt.irq     = int_en;
        end
    end

endmodule

// File: rtl/rxp_char_stage.sv
module rxp_char_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [1:0]        par_mode,
    input  logic              irq_en,
    input  logic              stat_clr,
    output logic [DATA_W-1:0] rx_buf,
    output logic              rx_done,
    output logic              rx_overrun,
    output logic              rx_par_odd,
    output logic              rx_irq
);
    import rxp_pkg::*;

    localparam int TOP = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] buf_v;
        rx_flags_t         flags;
    } stage_t;

    stage_t stage_d, stage_q;

    logic              accept;
    logic [DATA_W-1:0] char_fixed;
    logic              char_odd;
    rx_flags_t         flags_nxt;

    assign accept = rx_valid && !rx_break;

    rxp_parity_gen #(.DATA_W(DATA_W)) u_par (
        .raw_char    (rx_data),
        .mode        (par_mode),
        .stored_char (char_fixed),
        .weight_odd  (char_odd)
    );

    rxp_flag_next u_flags (
        .accept      (accept),
        .clr         (stat_clr),
        .int_en      (irq_en),
        .new_par_odd (char_odd),
        .cur         (stage_q.flags),
        .nxt         (flags_nxt)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.flags = flags_nxt;
        if (accept) begin
            stage_d.buf_v = char_fixed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign rx_buf     = stage_q.buf_v;
    assign rx_done    = stage_q.flags.done;
    assign rx_overrun = stage_q.flags.ovr;
    assign rx_par_odd = stage_q.flags.par_odd;
    assign rx_irq     = stage_q.flags.irq;

    assert_odd_weight_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && par_mode == 2'b01) |=> (^rx_buf) == 1'b1);

    assert_even_weight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && par_mode == 2'b10) |=> (^rx_buf) == 1'b0);

    assert_raw_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (par_mode == 2'b00 || par_mode == 2'b11)) |=> rx_buf[TOP] == $past(rx_data[TOP]));

    assert_par_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(accept) |-> rx_par_odd == (^rx_buf));

    assert_done_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rx_done);

    assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rx_done && !stat_clr) |=> rx_overrun);

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq || $past(accept));

    assert_break_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_break && !stat_clr) |=> $stable(rx_buf) && $stable(rx_done) && $stable(rx_overrun) && !rx_irq);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !accept) |=> !rx_done && !rx_overrun);

endmodule

// File: tb/rxp_char_stage_tb_top.sv
`timescale 1ns/1ps
module rxp_char_stage_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid, rx_break, irq_en, stat_clr;
    logic [7:0] rx_data;
    logic [1:0] par_mode;
    logic [7:0] rx_buf;
    logic       rx_done, rx_overrun, rx_par_odd, rx_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] m_buf;
    logic       m_done, m_ovr, m_par;

    always #2.5 clk = ~clk;

    rxp_char_stage #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_break(rx_break),
        .rx_data(rx_data), .par_mode(par_mode), .irq_en(irq_en), .stat_clr(stat_clr),
        .rx_buf(rx_buf), .rx_done(rx_done), .rx_overrun(rx_overrun),
        .rx_par_odd(rx_par_odd), .rx_irq(rx_irq)
    );

    function automatic int ones7(input logic [7:0] d);
        int n = 0;
        for (int i = 0; i < 7; i++) n += d[i];
        return n;
    endfunction

    function automatic logic [7:0] model_char(input logic [7:0] d, input logic [1:0] m);
        logic [7:0] r = d;
        if (m == 2'b01) r[7] = (ones7(d) % 2 == 0);
        else if (m == 2'b10) r[7] = (ones7(d) % 2 == 1);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk({req, " buf"}, rx_buf, m_buf);
        chk({req, " done"}, rx_done, m_done);
        chk({req, " ovr"}, rx_overrun, m_ovr);
        chk({req, " par"}, rx_par_odd, m_par);
    endtask

    // drive one strobe; outputs checked one cycle later
    task automatic send(input string req, input logic [7:0] d, input logic [1:0] m,
                        input logic brk, input logic clr, input logic ie);
        logic [7:0] c;
        int w;
        rx_valid = 1'b1; rx_data = d; par_mode = m; rx_break = brk;
        stat_clr = clr; irq_en = ie;
        @(negedge clk);
        rx_valid = 1'b0; rx_break = 1'b0; stat_clr = 1'b0;
        if (clr) begin m_done = 0; m_ovr = 0; end
        if (!brk) begin
            c = model_char(d, m);
            if (m_done) m_ovr = 1;
            m_done = 1;
            m_buf = c;
            w = ones7(c) + c[7];
            m_par = (w % 2 == 1);
        end
        chk_state(req);
        chk({req, " irq"}, rx_irq, (!brk && ie));
        @(negedge clk);
        chk({req, " irq end"}, rx_irq, 1'b0);
    endtask

    task automatic clear_status(input string req);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        m_done = 0; m_ovr = 0;
        chk_state(req);
    endtask

    task automatic t_reset;
        chk_state("R1");
        chk("R1 irq", rx_irq, 1'b0);
    endtask

    task automatic t_modes;
        send("R2 odd 41", 8'h41, 2'b01, 0, 1, 0);
        chk("R2 val", rx_buf, 8'hC1);
        send("R2 odd 87", 8'h87, 2'b01, 0, 1, 0);
        chk("R2 val2", rx_buf, 8'h07);
        send("R3 even 41", 8'h41, 2'b10, 0, 1, 0);
        chk("R3 val", rx_buf, 8'h41);
        send("R3 even 07", 8'h07, 2'b10, 0, 1, 0);
        chk("R3 val2", rx_buf, 8'h87);
        send("R4 none 83", 8'h83, 2'b00, 0, 1, 0);
        chk("R5 odd flag", rx_par_odd, 1'b1);
        send("R4 raw 03", 8'h03, 2'b11, 0, 1, 0);
        chk("R5 even flag", rx_par_odd, 1'b0);
    endtask

    task automatic t_overrun;
        clear_status("R10 clear");
        send("R6 first", 8'h55, 2'b00, 0, 0, 0);
        send("R7 second", 8'h2A, 2'b01, 0, 0, 0);
        chk("R7 ovr", rx_overrun, 1'b1);
        clear_status("R10 clr after ovr");
    endtask

    task automatic t_irq;
        send("R8 irq on", 8'h31, 2'b10, 0, 1, 1);
        send("R8 irq off", 8'h32, 2'b10, 0, 1, 0);
    endtask

    task automatic t_break;
        send("R9 setup", 8'h11, 2'b00, 0, 0, 0);
        send("R9 setup2", 8'h12, 2'b00, 0, 0, 0);
        send("R9 break", 8'hFF, 2'b01, 1, 0, 1);
    endtask

    task automatic t_clr_race;
        send("R10 race", 8'h60, 2'b01, 0, 1, 0);
        chk("R10 race done", rx_done, 1'b1);
        chk("R10 race ovr", rx_overrun, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; rx_valid = 0; rx_break = 0; irq_en = 0; stat_clr = 0;
        rx_data = 8'h00; par_mode = 2'b00;
        m_buf = 0; m_done = 0; m_ovr = 0; m_par = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_overrun();
        t_irq();
        t_break();
        t_clr_race();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule